// File: doc/BRIEF.md
# RTC Prescaler and Periodic Interrupt Source

This block turns a 32.768 kHz timebase into the one-per-second update strobe that drives a real-time clock's calendar logic. A 15-stage binary divider counts oscillator cycles. A full second is one complete wrap of the divider, and the update strobe fires each time the top stage rises. The same divider feeds a software-chosen tap that raises a sticky periodic flag. Software clears that flag with a one-cycle clear pulse.

A 3-bit mode field controls the divider. One code lets it run, two codes clear it and hold it at zero, and every other code freezes it where it stands. Releasing the divider from zero into run mode makes the first update strobe come after half a second. The first periodic flag after such a release comes after half of the chosen period. A 4-bit rate field chooses the tap. Code 0 turns the flag off. The whole block runs on the 32.768 kHz clock, one increment per clock.

Top module: `rtc_prescaler`

## Requirements
- R1: While `rst_n` is low at a clock edge, `div_count`, `upd_tick` and `pf_flag` all become 0.
- R2: While `div_ctrl` is 3'b110 or 3'b111, the divider is cleared to 0 at each clock edge and stays there.
- R3: While `div_ctrl` is any value other than 3'b010, 3'b110 or 3'b111, `div_count` keeps its value.
- R4: While `div_ctrl` is 3'b010, `div_count` increases by one on every clock edge and wraps from 32767 to 0.
- R5: After the divider is released from 0 into run mode, `upd_tick` is high for exactly one cycle. That cycle is the one in which `div_count` first reads 16384, which is 16384 clocks after release.
- R6: In steady running, `upd_tick` repeats every 32768 clocks.
- R7: For `rate_sel` code c from 3 to 15, `pf_flag` sets every 2^(c-1) clocks. After release from 0, the first set comes 2^(c-2) clocks after release.
- R8: `rate_sel` codes 1 and 2 behave exactly like codes 8 and 9. Their periods are 128 and 256 clocks, and their first sets come 64 and 128 clocks after release.
- R9: With `rate_sel` = 0, `pf_flag` never sets.
- R10: `pf_flag` stays high until a clock edge with `pf_clr` high. If a clear and a set fall on the same edge, the flag stays high.
- R11: While the divider is frozen or cleared, neither `upd_tick` nor `pf_flag` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_ctrl | input | 3 | Divider mode: 010 run, 110/111 clear, others freeze |
| rate_sel | input | 4 | Periodic tap code, 0 = off |
| pf_clr | input | 1 | One-cycle clear of the periodic flag |
| upd_tick | output | 1 | One-cycle strobe once per second |
| pf_flag | output | 1 | Sticky periodic flag |
| div_count | output | 15 | Current divider value |

## Verification
Two events can land on the same clock edge: a software clear of the periodic flag and a new tap rise that sets it. The bench uses rate code 3, whose period is four clocks. It holds `pf_clr` high from the cycle after the first set until past the second tap rise. At the colliding edge the flag must read 1, and it must drop on the edge that follows. The bench also lines up half-second and wrap points against the clock count from release. These checks show that the update strobe and the flag taps come from one shared divider phase.

// File: rtl/rtc_presc_pkg.sv
// Package: shared types and decode functions for the RTC prescaler.
// Assumes: rate codes index taps of a divider that is at least 15 bits wide.
package rtc_presc_pkg;

    typedef enum logic [1:0] {
        CHAIN_RUN   = 2'd0,
        CHAIN_CLEAR = 2'd1,
        CHAIN_HOLD  = 2'd2
    } chain_mode_e;

    localparam logic [2:0] CTRL_RUN = 3'b010;

    // Map the 3-bit mode field onto a divider action.
    function automatic chain_mode_e decode_mode(input logic [2:0] ctrl);
        if (ctrl == CTRL_RUN)       return CHAIN_RUN;
        else if (ctrl[2:1] == 2'b11) return CHAIN_CLEAR;
        else                         return CHAIN_HOLD;
    endfunction

    // Effective rate code: codes 1 and 2 fold onto codes 8 and 9.
    function automatic logic [3:0] effective_code(input logic [3:0] code);
        case (code)
            4'd1:    return 4'd8;
            4'd2:    return 4'd9;
            default: return code;
        endcase
    endfunction

    // Divider bit whose rising edge marks the flag event for a code (eff >= 3).
    function automatic logic [3:0] tap_bit(input logic [3:0] code);
        logic [3:0] eff;
        eff = effective_code(code);
        return eff - 4'd2;
    endfunction

endpackage

// File: rtl/rtc_div_chain.sv
// Module: binary divider chain with run / clear / freeze control.
// Produces the count, a per-bit rising-edge vector for this clock's step,
// and a registered one-cycle update strobe on each rise of the top bit.
// Assumes: one increment per clock of the 32.768 kHz domain.
module rtc_div_chain
    import rtc_presc_pkg::*;
#(
    parameter int DIV_BITS = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          div_ctrl,
    output logic [DIV_BITS-1:0] cnt_q,
    output logic [DIV_BITS-1:0] bit_rise,
    output logic                upd_tick
);
    localparam logic [DIV_BITS-1:0] ONE  = {{(DIV_BITS-1){1'b0}}, 1'b1};
    localparam logic [DIV_BITS-1:0] ZERO = '0;

    chain_mode_e        mode;
    logic [DIV_BITS-1:0] cnt_inc;

    // Decode the mode and compute which bits rise on this step.
    always_comb begin
        mode     = decode_mode(div_ctrl);
        cnt_inc  = cnt_q + ONE;
        bit_rise = (mode == CHAIN_RUN) ? (~cnt_q & cnt_inc) : ZERO;
    end

    // Divider register: advance, clear or freeze.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= ZERO;
        else if (mode == CHAIN_CLEAR) cnt_q <= ZERO;
        else if (mode == CHAIN_RUN)   cnt_q <= cnt_inc;
    end

    // Update strobe: top stage rising marks each second boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_tick <= 1'b0;
        else        upd_tick <= bit_rise[DIV_BITS-1];
    end

    assert_clear_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (div_ctrl[2:1] == 2'b11) |=> (cnt_q == ZERO));
    assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_ctrl != CTRL_RUN && div_ctrl[2:1] != 2'b11) |=> $stable(cnt_q));
    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_ctrl == CTRL_RUN) |=> (cnt_q == $past(cnt_q) + ONE));
    assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_tick |=> !upd_tick);
    assert_tick_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (div_ctrl != CTRL_RUN) |=> !upd_tick);

endmodule

// File: rtl/rtc_tap_sel.sv
// Module: picks one divider bit's rising edge as the periodic event.
// Assumes: DIV_BITS > 13 so that every code up to 15 has a tap.
module rtc_tap_sel
    import rtc_presc_pkg::*;
#(
    parameter int DIV_BITS = 15
) (
    input  logic [3:0]          rate_sel,
    input  logic [DIV_BITS-1:0] bit_rise,
    output logic                tap_set
);
    localparam int IDX_W = $clog2(DIV_BITS);

    logic [IDX_W-1:0] idx;

    // Select the tap for the current code; code 0 disables the event.
    always_comb begin
        idx     = IDX_W'(tap_bit(rate_sel));
        tap_set = (rate_sel != 4'd0) && bit_rise[idx];
    end

endmodule

// File: rtl/rtc_pf_flag.sv
// Module: sticky periodic flag with clear pulse; a set wins over a clear.
// Assumes: tap_set is a single-cycle event from the divider.
module rtc_pf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tap_set,
    input  logic pf_clr,
    output logic pf_flag
);
    // Flag register: set has priority, otherwise clear or keep.
    always_ff @(posedge clk) begin
        if (!rst_n)       pf_flag <= 1'b0;
        else if (tap_set) pf_flag <= 1'b1;
        else if (pf_clr)  pf_flag <= 1'b0;
    end

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_flag && !pf_clr) |=> pf_flag);
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tap_set |=> pf_flag);
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_clr && !tap_set) |=> !pf_flag);

endmodule

// File: rtl/rtc_prescaler.sv
// Module: top of the RTC prescaler. Connects the divider chain, the tap
// selector and the sticky flag. Assumes clk is the 32.768 kHz timebase.
module rtc_prescaler #(
    parameter int DIV_BITS = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          div_ctrl,
    input  logic [3:0]          rate_sel,
    input  logic                pf_clr,
    output logic                upd_tick,
    output logic                pf_flag,
    output logic [DIV_BITS-1:0] div_count
);
    logic [DIV_BITS-1:0] bit_rise;
    logic                tap_set;

    rtc_div_chain #(.DIV_BITS(DIV_BITS)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_ctrl (div_ctrl),
        .cnt_q    (div_count),
        .bit_rise (bit_rise),
        .upd_tick (upd_tick)
    );

    rtc_tap_sel #(.DIV_BITS(DIV_BITS)) u_tap (
        .rate_sel (rate_sel),
        .bit_rise (bit_rise),
        .tap_set  (tap_set)
    );

    rtc_pf_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap_set (tap_set),
        .pf_clr  (pf_clr),
        .pf_flag (pf_flag)
    );

    assert_flag_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 4'd0 && !pf_flag) |=> !pf_flag);
    assert_flag_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (div_ctrl != 3'b010 && !pf_flag) |=> !pf_flag);

endmodule

// File: tb/tb_rtc_prescaler.sv
module tb_rtc_prescaler;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  div_ctrl;
    logic [3:0]  rate_sel;
    logic        pf_clr;
    logic        upd_tick;
    logic        pf_flag;
    logic [14:0] div_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    rtc_prescaler dut (
        .clk(clk), .rst_n(rst_n), .div_ctrl(div_ctrl), .rate_sel(rate_sel),
        .pf_clr(pf_clr), .upd_tick(upd_tick), .pf_flag(pf_flag),
        .div_count(div_count)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance n clock edges, then stop on the following falling edge.
    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Clear the chain and flag, then release into run mode from zero.
    task automatic release_chain(input logic [3:0] code);
        div_ctrl = 3'b110;
        rate_sel = code;
        pf_clr   = 1'b1;
        run(2);
        pf_clr   = 1'b0;
        div_ctrl = 3'b010;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; div_ctrl = 3'b010; rate_sel = 4'd3; pf_clr = 1'b0;
        run(4);
        check("R1", "count in reset", int'(div_count), 0);
        check("R1", "tick in reset", int'(upd_tick), 0);
        check("R1", "flag in reset", int'(pf_flag), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_half_second_and_wrap;
        release_chain(4'd0);
        run(16383);
        check("R5", "tick before half second", int'(upd_tick), 0);
        check("R4", "count at 16383", int'(div_count), 16383);
        run(1);
        check("R5", "tick at half second", int'(upd_tick), 1);
        check("R5", "count at tick", int'(div_count), 16384);
        run(1);
        check("R5", "tick one cycle wide", int'(upd_tick), 0);
        run(16383);
        check("R4", "count wraps to zero", int'(div_count), 0);
        run(16383);
        check("R6", "tick before next second", int'(upd_tick), 0);
        run(1);
        check("R6", "tick one second later", int'(upd_tick), 1);
        check("R9", "flag stays off with code 0", int'(pf_flag), 0);
    endtask

    task automatic t_freeze_and_clear;
        release_chain(4'd3);
        run(100);
        check("R4", "count after 100", int'(div_count), 100);
        pf_clr = 1'b1; div_ctrl = 3'b000;
        run(1);
        pf_clr = 1'b0;
        run(49);
        check("R3", "frozen by 000", int'(div_count), 100);
        check("R11", "no flag while frozen", int'(pf_flag), 0);
        check("R11", "no tick while frozen", int'(upd_tick), 0);
        div_ctrl = 3'b101;
        run(5);
        check("R3", "frozen by 101", int'(div_count), 100);
        div_ctrl = 3'b010;
        run(1);
        check("R3", "resumes from held value", int'(div_count), 101);
        div_ctrl = 3'b111;
        run(1);
        check("R2", "111 clears", int'(div_count), 0);
        div_ctrl = 3'b010;
        run(7);
        div_ctrl = 3'b110;
        run(3);
        check("R2", "110 clears and holds", int'(div_count), 0);
    endtask

    // First set at half period, clear, next set one period later.
    task automatic t_rate(input logic [3:0] code, input int half, input string req);
        release_chain(code);
        run(half - 1);
        check(req, "flag before half period", int'(pf_flag), 0);
        run(1);
        check(req, "flag at half period", int'(pf_flag), 1);
        pf_clr = 1'b1;
        run(1);
        pf_clr = 1'b0;
        check("R10", "flag cleared", int'(pf_flag), 0);
        run(2 * half - 2);
        check(req, "flag before next period", int'(pf_flag), 0);
        run(1);
        check(req, "flag after one period", int'(pf_flag), 1);
        run(5);
        check("R10", "flag sticky", int'(pf_flag), 1);
    endtask

    task automatic t_code_off;
        release_chain(4'd0);
        run(600);
        check("R9", "code 0 flag", int'(pf_flag), 0);
    endtask

    task automatic t_collision;
        release_chain(4'd3);
        run(2);
        check("R7", "code 3 first set", int'(pf_flag), 1);
        pf_clr = 1'b1;
        run(1);
        check("R10", "cleared under clear", int'(pf_flag), 0);
        run(3);
        check("R10", "set wins over clear", int'(pf_flag), 1);
        run(1);
        check("R10", "clear after collision", int'(pf_flag), 0);
        pf_clr = 1'b0;
    endtask

    initial begin
        t_reset();
        t_half_second_and_wrap();
        t_freeze_and_clear();
        t_rate(4'd3, 2, "R7");
        t_rate(4'd6, 16, "R7");
        t_rate(4'd15, 8192, "R7");
        t_rate(4'd1, 64, "R8");
        t_rate(4'd2, 128, "R8");
        t_code_off();
        t_collision();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule